// File: doc/BRIEF.md
# Matrix Key Scanner with Key Request

This block scans a keyboard matrix of eight drive sources and four return lines. A frame timing generator outside the block marks each key-scan slot. It gives a slot-valid level, the index of the source for that slot, and a one-cycle end-of-slot pulse. While scanning is enabled, the block drives the addressed source for the length of the slot. It passes the four raw return lines through a two-stage synchronizer. At the end of the slot it writes the synchronized values into that source's row of the key memory.

The key memory holds 32 bits, one per key. A 1 means the key is pressed and a 0 means it is released. A key request flag is high while scanning is enabled and any stored bit is 1. The flag follows the stored data, so reading the memory never clears it.

A host reads the memory as four bytes through a pulse handshake. A start pulse rewinds the read pointer to the highest source pair. Each request pulse then returns the next byte one cycle later. When scanning is disabled, the memory keeps its contents, the source outputs stay idle and the request flag is held low.

Top module: `kbd_matrix_scan`

## Requirements
- R1: After reset the key memory is all zero, `key_req_o` is 0, `src_drv_o` is 0 and `rd_valid_o` is 0.
- R2: If `scan_en_i` and `slot_valid_i` are both high on a clock edge, then after that edge `src_drv_o` has exactly one bit set, bit `slot_idx_i`. Index 0 is source 1 and index 7 is source 8. Otherwise `src_drv_o` becomes 0.
- R3: On an edge where `scan_en_i`, `slot_valid_i` and `slot_end_i` are all high, the row for source `slot_idx_i` takes the values of `key_ret_i` from two edges earlier. The two-stage synchronizer causes this delay, so returns that are stable for at least three cycles before the slot ends are captured exactly. No other row changes.
- R4: While `scan_en_i` is low, no row is written and the memory keeps its last contents. Slot strobes are ignored.
- R5: While `scan_en_i` is high, `key_req_o` is 1 one cycle after any stored bit is 1. It is 0 one cycle after all stored bits are 0.
- R6: While `scan_en_i` is low, `key_req_o` is 0 from the next cycle on, whatever the memory holds.
- R7: Read byte k (k = 0..3) packs two sources. The upper nibble holds source 7-2k and the lower nibble holds source 8-2k. In each nibble, return line 1 sits at the nibble's top bit and return line 4 at its bottom bit. Source 1 with return 1 alone reads as 8'h80 in byte 3. Source 8 with return 4 alone reads as 8'h01 in byte 0.
- R8: A `rd_start_i` pulse sets the read pointer to byte 0 and takes priority over a simultaneous `rd_req_i`. Later request pulses return bytes 0, 1, 2 and 3 in that order, then wrap back to byte 0.
- R9: Reading changes neither the key memory nor `key_req_o`.
- R10: A `rd_req_i` pulse without `rd_start_i` gives `rd_valid_o` = 1 and the byte on `rd_data_o` in the next cycle. In every other cycle `rd_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_en_i | input | 1 | Key scanning enabled |
| slot_valid_i | input | 1 | A key-scan slot is active |
| slot_idx_i | input | 3 | Source index of the active slot (0 = source 1) |
| slot_end_i | input | 1 | Last cycle of the active slot |
| key_ret_i | input | 4 | Raw return lines, bit 0 = return 1, 1 = pressed |
| rd_start_i | input | 1 | Rewind the read pointer to byte 0 |
| rd_req_i | input | 1 | Request the next key byte |
| src_drv_o | output | 8 | Active source drive, one-hot during a slot |
| key_req_o | output | 1 | Any key pressed while scanning is enabled |
| rd_valid_o | output | 1 | `rd_data_o` is valid |
| rd_data_o | output | 8 | Key byte being read |

## Verification
The assertions assume three things about the inputs: `slot_idx_i` is in range, `slot_end_i` comes only inside a valid slot, and the return lines settle at least three cycles before a slot ends. The bench meets these by holding each slot for several cycles. It changes `key_ret_i` only between slots and raises `slot_end_i` only on the last cycle of a slot. Read pulses are one cycle wide and never overlap a slot end, so the byte read back matches the last completed scan.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;
  localparam int unsigned KS_NUM_SRC_DEF = 8;
  localparam int unsigned KS_NUM_RET_DEF = 4;
  localparam int unsigned KS_SYNC_DEF    = 2;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_START = 2'd1,
    RD_BYTE  = 2'd2
  } rd_op_e;
endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/kbd_src_drive.sv
module kbd_src_drive #(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               act_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [NUM_SRC-1:0] drv_o
);
  logic [NUM_SRC-1:0] drv_d, drv_q;

  always_comb begin
    drv_d = '0;
    if (act_i) drv_d[idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_q <= '0;
    else         drv_q <= drv_d;
  end

  assign drv_o = drv_q;
endmodule

// File: rtl/kbd_key_store.sv
module kbd_key_store #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned NUM_RET = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC),
  localparam int unsigned BITS   = NUM_SRC * NUM_RET
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [NUM_RET-1:0] wr_data_i,
  output logic [BITS-1:0]    mem_o,
  output logic               any_next_o
);
  logic [BITS-1:0] mem_d;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_row
    logic [NUM_RET-1:0] row_q, row_d;
    assign row_d = (wr_en_i && wr_idx_i == IDX_W'(g)) ? wr_data_i : row_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) row_q <= '0;
      else         row_q <= row_d;
    end
    assign mem_o[g*NUM_RET +: NUM_RET] = row_q;
    assign mem_d[g*NUM_RET +: NUM_RET] = row_d;
  end

  assign any_next_o = |mem_d;
endmodule

// File: rtl/kbd_byte_reader.sv
module kbd_byte_reader #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned NUM_RET = 4,
  localparam int unsigned BITS   = NUM_SRC * NUM_RET,
  localparam int unsigned BYTE_W = 2 * NUM_RET,
  localparam int unsigned NBYTES = NUM_SRC / 2,
  localparam int unsigned PTR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BITS-1:0]   mem_i,
  input  logic              rd_start_i,
  input  logic              rd_req_i,
  output logic              rd_valid_o,
  output logic [BYTE_W-1:0] rd_data_o
);
  import kbd_scan_pkg::*;

  logic [BYTE_W-1:0] byte_w [NBYTES];
  logic [PTR_W-1:0]  ptr_q;
  logic              valid_q;
  logic [BYTE_W-1:0] data_q;
  rd_op_e            op;

  // byte k: upper nibble = odd source (index NUM_SRC-2-2k), lower = even; return 1 at nibble top
  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    for (genvar r = 0; r < NUM_RET; r++) begin : g_bit
      assign byte_w[k][BYTE_W-1-r]  = mem_i[(NUM_SRC-2-2*k)*NUM_RET + r];
      assign byte_w[k][NUM_RET-1-r] = mem_i[(NUM_SRC-1-2*k)*NUM_RET + r];
    end
  end

  always_comb begin
    if (rd_start_i)    op = RD_START;
    else if (rd_req_i) op = RD_BYTE;
    else               op = RD_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (op)
        RD_START: ptr_q <= '0;
        RD_BYTE: begin
          valid_q <= 1'b1;
          data_q  <= byte_w[ptr_q];
          ptr_q   <= (ptr_q == PTR_W'(NBYTES-1)) ? '0 : ptr_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_data_o  = data_q;
endmodule

// File: rtl/kbd_matrix_scan.sv
module kbd_matrix_scan #(
  parameter int unsigned NUM_SRC     = kbd_scan_pkg::KS_NUM_SRC_DEF,
  parameter int unsigned NUM_RET     = kbd_scan_pkg::KS_NUM_RET_DEF,
  parameter int unsigned SYNC_STAGES = kbd_scan_pkg::KS_SYNC_DEF,
  localparam int unsigned IDX_W      = $clog2(NUM_SRC),
  localparam int unsigned BITS       = NUM_SRC * NUM_RET,
  localparam int unsigned BYTE_W     = 2 * NUM_RET
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scan_en_i,
  input  logic               slot_valid_i,
  input  logic [IDX_W-1:0]   slot_idx_i,
  input  logic               slot_end_i,
  input  logic [NUM_RET-1:0] key_ret_i,
  input  logic               rd_start_i,
  input  logic               rd_req_i,
  output logic [NUM_SRC-1:0] src_drv_o,
  output logic               key_req_o,
  output logic               rd_valid_o,
  output logic [BYTE_W-1:0]  rd_data_o
);
  logic [NUM_RET-1:0] ret_sync;
  logic [BITS-1:0]    key_mem;
  logic               any_next;
  logic               cap_en;
  logic               req_q;

  assign cap_en = scan_en_i && slot_valid_i && slot_end_i;

  kbd_sync #(.W(NUM_RET), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (key_ret_i),
    .q_o    (ret_sync)
  );

  kbd_src_drive #(.NUM_SRC(NUM_SRC)) u_drive (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (scan_en_i && slot_valid_i),
    .idx_i  (slot_idx_i),
    .drv_o  (src_drv_o)
  );

  kbd_key_store #(.NUM_SRC(NUM_SRC), .NUM_RET(NUM_RET)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (cap_en),
    .wr_idx_i   (slot_idx_i),
    .wr_data_i  (ret_sync),
    .mem_o      (key_mem),
    .any_next_o (any_next)
  );

  kbd_byte_reader #(.NUM_SRC(NUM_SRC), .NUM_RET(NUM_RET)) u_reader (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mem_i      (key_mem),
    .rd_start_i (rd_start_i),
    .rd_req_i   (rd_req_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

  // request follows stored data, not reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= scan_en_i && any_next;
  end

  assign key_req_o = req_q;
endmodule

// File: rtl/kbd_matrix_scan_chk.sv
module kbd_matrix_scan_chk #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned NUM_RET = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC),
  localparam int unsigned BITS   = NUM_SRC * NUM_RET
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               scan_en_i,
  input logic               slot_valid_i,
  input logic [IDX_W-1:0]   slot_idx_i,
  input logic               rd_start_i,
  input logic               rd_req_i,
  input logic [NUM_SRC-1:0] src_drv_o,
  input logic               key_req_o,
  input logic               rd_valid_o,
  input logic [BITS-1:0]    key_mem
);
  p_drv_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_drv_o));

  p_drv_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_en_i && slot_valid_i) |=> ($countones(src_drv_o) == 1 && src_drv_o[$past(slot_idx_i)]));

  p_drv_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(scan_en_i && slot_valid_i) |=> (src_drv_o == '0));

  p_mem_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_en_i |=> $stable(key_mem));

  p_req_tracks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(scan_en_i) |-> (key_req_o == (|key_mem)));

  p_req_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_en_i |=> !key_req_o);

  p_rd_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !rd_start_i) |=> rd_valid_o);

  p_rd_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_i && !rd_start_i) |=> !rd_valid_o);
endmodule

bind kbd_matrix_scan kbd_matrix_scan_chk #(.NUM_SRC(NUM_SRC), .NUM_RET(NUM_RET)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scan_en_i    (scan_en_i),
  .slot_valid_i (slot_valid_i),
  .slot_idx_i   (slot_idx_i),
  .rd_start_i   (rd_start_i),
  .rd_req_i     (rd_req_i),
  .src_drv_o    (src_drv_o),
  .key_req_o    (key_req_o),
  .rd_valid_o   (rd_valid_o),
  .key_mem      (key_mem)
);

// File: tb/tb_kbd_matrix_scan.sv
`timescale 1ns/1ps
module tb_kbd_matrix_scan;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scan_en_i = 1'b0;
  logic       slot_valid_i = 1'b0;
  logic [2:0] slot_idx_i = '0;
  logic       slot_end_i = 1'b0;
  logic [3:0] key_ret_i = '0;
  logic       rd_start_i = 1'b0;
  logic       rd_req_i = 1'b0;
  logic [7:0] src_drv_o;
  logic       key_req_o;
  logic       rd_valid_o;
  logic [7:0] rd_data_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [3:0] exp_row [8];

  always #2 clk_i = ~clk_i;

  kbd_matrix_scan dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .scan_en_i(scan_en_i),
    .slot_valid_i(slot_valid_i), .slot_idx_i(slot_idx_i), .slot_end_i(slot_end_i),
    .key_ret_i(key_ret_i), .rd_start_i(rd_start_i), .rd_req_i(rd_req_i),
    .src_drv_o(src_drv_o), .key_req_o(key_req_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R7 packing computed from the requirement text
  function automatic logic [7:0] exp_byte(input int k);
    logic [7:0] b = '0;
    for (int r = 0; r < 4; r++) begin
      b[7-r] = exp_row[6-2*k][r];
      b[3-r] = exp_row[7-2*k][r];
    end
    return b;
  endfunction

  function automatic bit exp_any();
    for (int s = 0; s < 8; s++) if (exp_row[s] != 0) return 1'b1;
    return 1'b0;
  endfunction

  // one key-scan slot; returns settle before the slot, captured on its last cycle
  task automatic run_slot(input int idx, input logic [3:0] ret, input bit cap);
    key_ret_i = ret;
    repeat (4) @(negedge clk_i);
    slot_valid_i = 1'b1;
    slot_idx_i   = 3'(idx);
    @(negedge clk_i);
    if (scan_en_i)
      check(src_drv_o == 8'(1 << idx), "R2 drive", src_drv_o, 1 << idx);
    else
      check(src_drv_o == 8'h00, "R4 drive idle when disabled", src_drv_o, 0);
    slot_end_i = 1'b1;
    @(negedge clk_i);
    slot_end_i   = 1'b0;
    slot_valid_i = 1'b0;
    if (cap) exp_row[idx] = ret;
    @(negedge clk_i);
    check(src_drv_o == 8'h00, "R2 drive released", src_drv_o, 0);
  endtask

  task automatic read_all(input string req);
    rd_start_i = 1'b1;
    @(negedge clk_i);
    rd_start_i = 1'b0;
    check(rd_valid_o == 1'b0, "R10 no valid on start", rd_valid_o, 0);
    for (int k = 0; k < 4; k++) begin
      rd_req_i = 1'b1;
      @(negedge clk_i);
      rd_req_i = 1'b0;
      check(rd_valid_o == 1'b1, "R10 valid", rd_valid_o, 1);
      check(rd_data_o == exp_byte(k), req, rd_data_o, exp_byte(k));
    end
    @(negedge clk_i);
    check(rd_valid_o == 1'b0, "R10 valid drops", rd_valid_o, 0);
  endtask

  task automatic t_reset_r1();
    for (int s = 0; s < 8; s++) exp_row[s] = '0;
    check(key_req_o == 1'b0, "R1 key_req", key_req_o, 0);
    check(src_drv_o == 8'h00, "R1 src_drv", src_drv_o, 0);
    check(rd_valid_o == 1'b0, "R1 rd_valid", rd_valid_o, 0);
    scan_en_i = 1'b1;
    @(negedge clk_i);
    read_all("R1 memory clear");
  endtask

  task automatic t_corner_bits_r7();
    run_slot(0, 4'b0001, 1'b1);   // source 1, return 1
    read_all("R7 source1 return1");
    check(exp_byte(3) == 8'h80, "R7 model byte3", exp_byte(3), 8'h80);
    run_slot(0, 4'b0000, 1'b1);
    run_slot(7, 4'b1000, 1'b1);   // source 8, return 4
    read_all("R7 source8 return4");
    check(exp_byte(0) == 8'h01, "R7 model byte0", exp_byte(0), 8'h01);
    check(key_req_o == 1'b1, "R5 req set", key_req_o, 1);
  endtask

  task automatic t_full_scan_r3();
    for (int s = 0; s < 8; s++) run_slot(s, 4'((s * 5 + 3) & 15), 1'b1);
    read_all("R3 full scan");
    check(key_req_o == exp_any(), "R5 req after scan", key_req_o, exp_any());
  endtask

  task automatic t_read_no_clear_r9();
    read_all("R9 second read unchanged");
    check(key_req_o == 1'b1, "R9 req kept after reads", key_req_o, 1);
    // R8 wrap: fifth request returns byte 0
    rd_start_i = 1'b1; @(negedge clk_i); rd_start_i = 1'b0;
    for (int k = 0; k < 5; k++) begin
      rd_req_i = 1'b1; @(negedge clk_i); rd_req_i = 1'b0;
    end
    check(rd_data_o == exp_byte(0), "R8 wrap to byte0", rd_data_o, exp_byte(0));
    // R8 start wins over request
    rd_req_i = 1'b1; @(negedge clk_i);
    rd_start_i = 1'b1; @(negedge clk_i);
    rd_start_i = 1'b0; rd_req_i = 1'b0;
    check(rd_valid_o == 1'b0, "R8 start priority", rd_valid_o, 0);
    rd_req_i = 1'b1; @(negedge clk_i); rd_req_i = 1'b0;
    check(rd_data_o == exp_byte(0), "R8 restart at byte0", rd_data_o, exp_byte(0));
  endtask

  task automatic t_disable_r4_r6();
    scan_en_i = 1'b0;
    @(negedge clk_i);
    check(key_req_o == 1'b0, "R6 req low when disabled", key_req_o, 0);
    for (int s = 0; s < 8; s++) run_slot(s, ~4'(s), 1'b0);
    check(key_req_o == 1'b0, "R6 req stays low", key_req_o, 0);
    read_all("R4 memory retained");
    scan_en_i = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    check(key_req_o == exp_any(), "R5 req returns", key_req_o, exp_any());
  endtask

  task automatic t_release_r5();
    for (int s = 0; s < 7; s++) run_slot(s, 4'h0, 1'b1);
    check(key_req_o == 1'b1, "R5 req held by last key", key_req_o, 1);
    run_slot(7, 4'h0, 1'b1);
    check(key_req_o == 1'b0, "R5 req clears when all zero", key_req_o, 0);
    read_all("R5 all released");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_r1();
    t_corner_bits_r7();
    t_full_scan_r3();
    t_read_no_clear_r9();
    t_disable_r4_r6();
    t_release_r5();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule